// File: doc/BRIEF.md
# Clock Distributor Serial Configuration Sequencer

This block sets up an external clock distribution device through a slow serial port made of a clock, an active-low enable, a data output and a data input. A start request writes all nine registers of the device from one of two built-in tables, primary or secondary. Each register goes out in its own 32-bit transaction, least significant bit first. The 4-bit register number sits in the low nibble of the word and the 28-bit payload sits above it.

A verify request reads one register back and compares it with the expected table value. It uses two transactions. The first sends a read command for the register. The second clocks 32 bits in from the device while the data output stays low. The low nibble of the returned word holds the address and is dropped before the compare.

A wake request runs a fixed power-down and sync pulse sequence on two further active-low pins. Only one operation runs at a time. Its end is marked by a one-cycle done pulse.

Top module: `refclk_cfg_seq`

## Requirements
- R1: After reset, enable, power-down and sync are high, the serial clock and data output are low, and busy, done and mismatch are low.
- R2: Each transaction drives enable low, gives exactly 32 rising edges of the serial clock, then drives enable high. The serial clock is low whenever enable is high. Enable stays high for at least 2*DIV system cycles between transactions of one operation.
- R3: Words go out least significant bit first. Data out changes only while the serial clock is low, and it is stable for at least DIV system cycles before each rising edge. Each serial clock phase lasts DIV system cycles.
- R4: A start request sends nine transactions for registers 0, 1, ..., 8 in that order. Each word is (table value << 4) | register number, with the register number in bits 3:0.
- R5: With table_sel_i = 0 at start (primary), the values are 0x01540000 for registers 0-4, then 0x000009D4, 0x01001000, 0x01400000 and 0x00000180 for registers 5, 6, 7 and 8.
- R6: With table_sel_i = 1 at start (secondary), the values are 0x01540020 for registers 0-4, then 0x0000019B, 0x01001000, 0x01400000 and 0x00000180 for registers 5, 6, 7 and 8.
- R7: A verify request sends the word (index << 4) | 0xE, with 0xE in bits 3:0. It then runs a second 32-clock transaction with data out held low.
- R8: During the second verify transaction, data in is sampled in each clock high phase, least significant bit first. The word is shifted right by 4 and compared with the table entry chosen by table_sel_i and the index. Indices above 8 expect zero. mismatch_o is set at done if the two differ and cleared otherwise. Any new operation clears it.
- R9: A wake request keeps enable high and the serial clock low. It drives power-down low, then high, then sync low, then high. Each step lasts WAIT_CYC cycles, and done follows WAIT_CYC cycles after the last step.
- R10: busy_o is high from the cycle after an accepted request until the cycle in which the final enable rise (or the end of the wake sequence) happens. In that cycle done_o pulses for one cycle. Requests that arrive while busy have no effect.
- R11: When several requests arrive in the same idle cycle, start wins over verify and verify wins over wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a write of the full table |
| table_sel_i | input | 1 | Table choice, 0 primary, 1 secondary; sampled with start_i or verify_i |
| verify_i | input | 1 | Request a readback compare |
| verify_idx_i | input | 4 | Register index for verify |
| wake_i | input | 1 | Request the power-down/sync wake sequence |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| mismatch_o | output | 1 | Result of the last verify |
| sclk_o | output | 1 | Serial clock |
| sen_n_o | output | 1 | Active-low serial enable |
| sdo_o | output | 1 | Serial data to the device |
| sdi_i | input | 1 | Serial data from the device |
| pdn_n_o | output | 1 | Active-low power-down |
| sync_n_o | output | 1 | Active-low sync |

## Verification
The hardest situation to reach is a readback that disagrees with the table, because the device is outside the block. The bench therefore models the device. The model stores every write word it captures and answers a read command with the stored payload and the address in the low nibble. A mismatch is then produced without any back door: the secondary table is written, and the registers whose primary and secondary values differ are verified against the primary table. The same model measures data setup time at every rising edge. Requests that collide in one cycle, or that arrive while busy, are checked by counting the transactions and power-down pulses the model sees.

// File: rtl/refclk_cfg_seq.sv
module refclk_cfg_seq #(
  parameter int DIV      = 4,
  parameter int WAIT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       table_sel_i,
  input  logic       verify_i,
  input  logic [3:0] verify_idx_i,
  input  logic       wake_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       mismatch_o,
  output logic       sclk_o,
  output logic       sen_n_o,
  output logic       sdo_o,
  input  logic       sdi_i,
  output logic       pdn_n_o,
  output logic       sync_n_o
);
  localparam int NREG = 9;
  localparam int GAPN = 2 * DIV;
  localparam int CMAX = (WAIT_CYC > GAPN) ? WAIT_CYC : GAPN;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] D_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] G_LAST = CW'(GAPN - 1);
  localparam logic [CW-1:0] W_LAST = CW'(WAIT_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_XFER, S_GAP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [4:0]  bitn;
  logic [3:0]  idx;
  logic [1:0]  step;
  logic        tsel, op_vfy, rd;
  logic [31:0] sh, rx;
  logic [31:0] word_w, rx_nxt;

  function automatic logic [27:0] tbl(input logic s, input logic [3:0] i);
    case (i)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: tbl = s ? 28'h1540020 : 28'h1540000;
      4'd5:    tbl = s ? 28'h000019B : 28'h00009D4;
      4'd6:    tbl = 28'h1001000;
      4'd7:    tbl = 28'h1400000;
      4'd8:    tbl = 28'h0000180;
      default: tbl = 28'h0;
    endcase
  endfunction

  assign busy_o = (st != S_IDLE);
  assign rx_nxt = {sdi_i, rx[31:1]};
  assign word_w = rd ? 32'h0 : (op_vfy ? {24'h0, idx, 4'hE} : {tbl(tsel, idx), idx});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; idx <= '0; step <= '0;
      tsel <= 1'b0; op_vfy <= 1'b0; rd <= 1'b0; sh <= '0; rx <= '0;
      done_o <= 1'b0; mismatch_o <= 1'b0;
      sclk_o <= 1'b0; sen_n_o <= 1'b1; sdo_o <= 1'b0;
      pdn_n_o <= 1'b1; sync_n_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_i) begin
            tsel <= table_sel_i; idx <= '0; op_vfy <= 1'b0; rd <= 1'b0;
            mismatch_o <= 1'b0; st <= S_GAP;
          end else if (verify_i) begin
            tsel <= table_sel_i; idx <= verify_idx_i; op_vfy <= 1'b1; rd <= 1'b0;
            mismatch_o <= 1'b0; st <= S_GAP;
          end else if (wake_i) begin
            mismatch_o <= 1'b0; pdn_n_o <= 1'b0; step <= '0; st <= S_WAKE;
          end
        end
        S_WAKE: begin
          cnt <= cnt + 1'b1;
          if (cnt == W_LAST) begin
            cnt  <= '0;
            step <= step + 1'b1;
            case (step)
              2'd0: pdn_n_o  <= 1'b1;
              2'd1: sync_n_o <= 1'b0;
              2'd2: sync_n_o <= 1'b1;
              default: begin st <= S_IDLE; done_o <= 1'b1; end
            endcase
          end
        end
        S_GAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == G_LAST) begin
            cnt <= '0; bitn <= '0;
            sh <= word_w; sdo_o <= word_w[0]; sen_n_o <= 1'b0;
            st <= S_XFER;
          end
        end
        S_XFER: begin
          cnt <= cnt + 1'b1;
          if (cnt == D_LAST) begin
            cnt <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
            end else begin
              sclk_o <= 1'b0;
              rx <= rx_nxt;
              if (bitn == 5'd31) begin
                sen_n_o <= 1'b1;
                sdo_o   <= 1'b0;
                if (!op_vfy) begin
                  if (idx == 4'(NREG - 1)) begin
                    st <= S_IDLE; done_o <= 1'b1;
                  end else begin
                    idx <= idx + 1'b1; st <= S_GAP;
                  end
                end else if (!rd) begin
                  rd <= 1'b1; st <= S_GAP;
                end else begin
                  mismatch_o <= (rx_nxt[31:4] != tbl(tsel, idx));
                  st <= S_IDLE; done_o <= 1'b1;
                end
              end else begin
                bitn  <= bitn + 1'b1;
                sh    <= sh >> 1;
                sdo_o <= sh[1];
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refclk_cfg_seq_chk.sv
module refclk_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sen_n_o,
  input logic sdo_o,
  input logic pdn_n_o,
  input logic sync_n_o
);
  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n_o |-> !sclk_o);
  // R3
  sdo_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdo_o));
  // R9
  no_wake_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_n_o |-> (pdn_n_o && sync_n_o));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R10
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));
  // R2
  idle_enable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sen_n_o);
endmodule

bind refclk_cfg_seq refclk_cfg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .sclk_o(sclk_o), .sen_n_o(sen_n_o), .sdo_o(sdo_o), .pdn_n_o(pdn_n_o),
  .sync_n_o(sync_n_o)
);

// File: tb/refclk_cfg_seq_tb.sv
`timescale 1ns/1ps
module refclk_cfg_seq_tb_top;
  localparam int DIV = 2;
  localparam int WC  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, table_sel_i = 0, verify_i = 0, wake_i = 0, sdi_i = 0;
  logic [3:0] verify_idx_i = 0;
  logic busy_o, done_o, mismatch_o, sclk_o, sen_n_o, sdo_o, pdn_n_o, sync_n_o;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  refclk_cfg_seq #(.DIV(DIV), .WAIT_CYC(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .table_sel_i(table_sel_i),
    .verify_i(verify_i), .verify_idx_i(verify_idx_i), .wake_i(wake_i),
    .busy_o(busy_o), .done_o(done_o), .mismatch_o(mismatch_o), .sclk_o(sclk_o),
    .sen_n_o(sen_n_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .pdn_n_o(pdn_n_o),
    .sync_n_o(sync_n_o)
  );

  // device model
  logic [31:0] words [0:15];
  int          nbits [0:15];
  int          nw = 0, viol = 0, pdn_falls = 0;
  logic [27:0] regs [0:8];
  logic [31:0] w = 0, rdword = 0;
  int          bitc = 0, rcnt = 0;
  bit          rd_pend = 0;
  time         t_sdo = 0;

  initial for (int i = 0; i < 9; i++) regs[i] = '0;

  always @(sdo_o) t_sdo = $time;
  always @(negedge pdn_n_o) pdn_falls++;

  always @(negedge sen_n_o) begin
    bitc = 0; rcnt = 0; w = 0;
    sdi_i = rd_pend ? rdword[0] : 1'b0;
  end
  always @(posedge sclk_o) if (!sen_n_o) begin
    if ($time - t_sdo < DIV * 20) viol++;
    w = {sdo_o, w[31:1]};
    bitc++; rcnt++;
  end
  always @(negedge sclk_o) if (!sen_n_o && rd_pend && rcnt < 32) sdi_i = rdword[rcnt];
  always @(posedge sen_n_o) if (rst_n) begin
    if (nw < 16) begin words[nw] = w; nbits[nw] = bitc; end
    nw++;
    if (rd_pend) rd_pend = 0;
    else if (w[3:0] == 4'hE) begin
      rd_pend = 1;
      rdword = (w[7:4] < 9) ? {regs[w[7:4]], w[7:4]} : {28'h0, w[7:4]};
    end else if (w[3:0] < 9) regs[w[3:0]] = w[31:4];
  end

  function automatic logic [27:0] expv(input bit s, input int i);
    if (i < 5) return s ? 28'h1540020 : 28'h1540000;
    if (i == 5) return s ? 28'h000019B : 28'h00009D4;
    if (i == 6) return 28'h1001000;
    if (i == 7) return 28'h1400000;
    if (i == 8) return 28'h0000180;
    return 28'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done_o, "R10 done seen", {31'h0, done_o}, 32'h1);
    @(negedge clk);
    chk(!done_o && !busy_o, "R10 done one cycle, busy low", {30'h0, done_o, busy_o}, 32'h0);
  endtask

  task automatic t_reset();
    chk(sen_n_o && pdn_n_o && sync_n_o, "R1 high pins", {29'h0, sen_n_o, pdn_n_o, sync_n_o}, 32'h7);
    chk(!sclk_o && !sdo_o, "R1 low pins", {30'h0, sclk_o, sdo_o}, 32'h0);
    chk(!busy_o && !done_o && !mismatch_o, "R1 flags", {29'h0, busy_o, done_o, mismatch_o}, 32'h0);
  endtask

  task automatic t_write(input bit sel, input bit poke);
    int c;
    nw = 0; viol = 0;
    @(negedge clk); start_i = 1; table_sel_i = sel;
    @(negedge clk); start_i = 0;
    chk(busy_o, "R10 busy after start", {31'h0, busy_o}, 32'h1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start_i = 1; verify_i = 1; wake_i = 1; table_sel_i = !sel;
      @(negedge clk); start_i = 0; verify_i = 0; wake_i = 0; table_sel_i = sel;
    end
    wait_done(c);
    chk(nw == 9, "R4 nine transactions", nw, 9);
    chk(viol == 0, "R3 setup before rise", viol, 0);
    for (int i = 0; i < 9 && i < nw; i++) begin
      chk(nbits[i] == 32, "R2 32 clocks", nbits[i], 32);
      chk(words[i] == {expv(sel, i), 4'(i)}, sel ? "R6 secondary word" : "R5 primary word",
          words[i], {expv(sel, i), 4'(i)});
    end
  endtask

  task automatic t_verify(input bit sel, input logic [3:0] ix, input bit exp_mm);
    int c;
    nw = 0; viol = 0;
    @(negedge clk); verify_i = 1; table_sel_i = sel; verify_idx_i = ix;
    @(negedge clk); verify_i = 0;
    wait_done(c);
    chk(nw == 2, "R7 two transactions", nw, 2);
    chk(words[0] == {24'h0, ix, 4'hE}, "R7 read command", words[0], {24'h0, ix, 4'hE});
    chk(words[1] == 32'h0, "R7 data low in read", words[1], 32'h0);
    chk(nbits[1] == 32, "R2 read 32 clocks", nbits[1], 32);
    chk(mismatch_o == exp_mm, "R8 compare result", {31'h0, mismatch_o}, {31'h0, exp_mm});
  endtask

  task automatic t_wake();
    int c = 0, tpf = -1, tpr = -1, tsf = -1, tsr = -1, td = -1;
    nw = 0;
    @(negedge clk); wake_i = 1;
    @(negedge clk); wake_i = 0;
    while (td < 0 && c < 1000) begin
      if (!pdn_n_o && tpf < 0) tpf = c;
      if (pdn_n_o && tpf >= 0 && tpr < 0) tpr = c;
      if (!sync_n_o && tsf < 0) tsf = c;
      if (sync_n_o && tsf >= 0 && tsr < 0) tsr = c;
      if (done_o) td = c;
      if (!sen_n_o || sclk_o) chk(0, "R9 enable high during wake", {30'h0, sen_n_o, sclk_o}, 32'h2);
      @(negedge clk); c++;
    end
    chk(tpf == 0, "R9 power-down low first", tpf, 0);
    chk(tpr - tpf == WC, "R9 power-down width", tpr - tpf, WC);
    chk(tsf - tpr == WC, "R9 sync after power-down", tsf - tpr, WC);
    chk(tsr - tsf == WC, "R9 sync width", tsr - tsf, WC);
    chk(td - tsr == WC, "R9 done after last wait", td - tsr, WC);
    chk(nw == 0, "R9 no transaction", nw, 0);
  endtask

  task automatic t_priority();
    int c, pf;
    pf = pdn_falls; nw = 0;
    @(negedge clk); start_i = 1; verify_i = 1; wake_i = 1; table_sel_i = 0; verify_idx_i = 3;
    @(negedge clk); start_i = 0; verify_i = 0; wake_i = 0;
    wait_done(c);
    chk(nw == 9, "R11 start wins", nw, 9);
    chk(pdn_falls == pf, "R11 no wake", pdn_falls, pf);
    chk(words[0] == {expv(0, 0), 4'd0}, "R11 first word is write", words[0], {expv(0, 0), 4'd0});
    nw = 0;
    @(negedge clk); verify_i = 1; wake_i = 1; table_sel_i = 0; verify_idx_i = 6;
    @(negedge clk); verify_i = 0; wake_i = 0;
    wait_done(c);
    chk(nw == 2 && pdn_falls == pf, "R11 verify over wake", nw, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(0, 1);
    t_verify(0, 4'd5, 0);
    t_write(1, 0);
    t_verify(1, 4'd5, 0);
    t_verify(0, 4'd5, 1);
    t_verify(0, 4'd0, 1);
    t_verify(0, 4'd6, 0);
    t_verify(1, 4'd12, 0);
    t_verify(0, 4'd5, 1);
    t_wake();
    chk(!mismatch_o, "R8 cleared by new op", {31'h0, mismatch_o}, 32'h0);
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule